// File: doc/BRIEF.md
# Registered Barrel Shifter with Fill Bit

This block holds one data byte in a register that captures the input only while a load enable is high. A combinational barrel shifter sits behind that register. It moves the held value left or right by 0 to 8 positions. In shift mode, the positions that empty out take the value of a separate fill-bit input. In rotate mode, the bits that leave one end come back in at the other end.

The shift amount is a 4-bit unsigned input. Any value above 8 behaves exactly like 8. The shifter is built from log2 stages that move the value by 1, 2 and 4 positions, plus one full-width path for an amount of 8. The output follows the held value and the live control inputs without waiting for a clock. Only the byte register is clocked, and it clears synchronously on reset.

A control module decodes the amount, direction, mode and fill inputs into a small strobe bundle. A datapath module holds the register and the shift stages. A thin top module joins the two.

Top module: `bshift_top`

## Requirements
- R1: On a rising clock edge with `rst` low and `loadEn` high, the held value becomes `dataIn`.
- R2: On a rising clock edge with `rst` low and `loadEn` low, the held value does not change, whatever `dataIn` does.
- R3: On a rising clock edge with `rst` high, the held value becomes 0. Reset takes priority over `loadEn`.
- R4: With `rotEn`=1, the output is the held value rotated by the amount. `dirLeft`=1 rotates toward the MSB, so bit i moves to bit (i+n) mod 8. `dirLeft`=0 rotates toward the LSB. The number of ones is preserved.
- R5: With `rotEn`=0, the output is the held value shifted by the amount. `dirLeft`=1 shifts toward the MSB and `dirLeft`=0 shifts toward the LSB. Every vacated position equals `fillBit`.
- R6: An amount of 0 gives an output equal to the held value, in every direction and mode and for every fill value.
- R7: An amount of 8 gives all eight output bits equal to `fillBit` in shift mode, and the unchanged held value in rotate mode.
- R8: Amounts from 9 to 15 give exactly the output that an amount of 8 gives.
- R9: The output reflects changes to `dirLeft`, `rotEn`, `fillBit` and `shiftAmt` within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the holding register |
| rst | input | 1 | Synchronous reset, active high; clears the register |
| dataIn | input | 8 | Byte to capture |
| loadEn | input | 1 | Capture enable for the register |
| dirLeft | input | 1 | 1 = toward the MSB, 0 = toward the LSB |
| rotEn | input | 1 | 1 = rotate, 0 = shift with fill |
| fillBit | input | 1 | Value placed in vacated positions in shift mode |
| shiftAmt | input | 4 | Unsigned amount; values above 8 act as 8 |
| dataOut | output | 8 | Shifted or rotated held value |

## Verification
Several properties are checked by assertions on every cycle:
- The register captures the input when enabled and keeps its value when not.
- The amount decode selects the full-width path for any amount of 8 or more.
- An amount of 0 passes the held value through.
- A full-width shift produces all fill bits.
- Rotation keeps the count of ones.

Only the bench's scenarios can show that each output bit lands in the right position for each direction. The same holds for the fill going into the correct end, for reset winning over a simultaneous load, and for the output following control changes with no clock edge in between. The bench checks these against a reference model.

// File: rtl/bshift_pkg.sv
package bshift_pkg;

  // Direction encoding on the dirLeft input.
  typedef enum logic {
    DIR_RIGHT = 1'b0,
    DIR_LEFT  = 1'b1
  } shiftDir_e;

  // Strobes passed from the control decode to the datapath.
  typedef struct packed {
    logic fullWidth;   // amount reaches the data width
    logic goLeft;      // move toward the MSB
    logic rotate;      // wrap bits instead of filling
    logic fill;        // value for vacated positions
  } shiftCtl_t;

endpackage

// File: rtl/bshift_ctrl.sv
module bshift_ctrl
  import bshift_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int AMT_W = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         dirLeft,
  input  logic                         rotEn,
  input  logic                         fillBit,
  input  logic [AMT_W-1:0]             shiftAmt,
  output shiftCtl_t                    ctl,
  output logic [$clog2(WIDTH)-1:0]     stageEn
);

  localparam int STAGES = $clog2(WIDTH);
  localparam logic [AMT_W:0] WIDTH_L = (AMT_W+1)'(WIDTH);

  logic      atFull;
  shiftDir_e dirSel;

  always_comb begin
    atFull = ({1'b0, shiftAmt} >= WIDTH_L);
    dirSel = shiftDir_e'(dirLeft);
    ctl.fullWidth = atFull;
    ctl.goLeft    = (dirSel == DIR_LEFT);
    ctl.rotate    = rotEn;
    ctl.fill      = fillBit;
    // Amounts at or above the width use only the full-width path.
    stageEn = atFull ? '0 : shiftAmt[STAGES-1:0];
  end

  // R8: any amount of WIDTH or more selects the full-width path with no stage active
  a_r8_clamp_full: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, shiftAmt} >= WIDTH_L) |-> (ctl.fullWidth && (stageEn == '0)));

  // R6: amount zero enables nothing
  a_r6_zero_decode: assert property (@(posedge clk) disable iff (rst)
    (shiftAmt == '0) |-> (!ctl.fullWidth && (stageEn == '0)));

endmodule

// File: rtl/bshift_datapath.sv
module bshift_datapath
  import bshift_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [WIDTH-1:0]             dataIn,
  input  logic                         loadEn,
  input  shiftCtl_t                    ctl,
  input  logic [$clog2(WIDTH)-1:0]     stageEn,
  output logic [WIDTH-1:0]             shOut
);

  localparam int STAGES = $clog2(WIDTH);

  logic [WIDTH-1:0] holdReg;
  logic [WIDTH-1:0] stg [0:STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      holdReg <= '0;
    end else if (loadEn) begin
      holdReg <= dataIn;
    end
  end

  assign stg[0] = holdReg;

  // One stage per power of two: stage k moves by 2**k positions.
  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    localparam int SH = 1 << k;
    logic [WIDTH-1:0] leftVal;
    logic [WIDTH-1:0] rightVal;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      if (i >= SH) begin : g_lin
        assign leftVal[i] = stg[k][i-SH];
      end else begin : g_lwrap
        assign leftVal[i] = ctl.rotate ? stg[k][i-SH+WIDTH] : ctl.fill;
      end
      if (i + SH < WIDTH) begin : g_rin
        assign rightVal[i] = stg[k][i+SH];
      end else begin : g_rwrap
        assign rightVal[i] = ctl.rotate ? stg[k][i+SH-WIDTH] : ctl.fill;
      end
    end

    assign stg[k+1] = stageEn[k] ? (ctl.goLeft ? leftVal : rightVal) : stg[k];
  end

  // Full-width move: rotating returns the value, shifting leaves only fill.
  always_comb begin
    if (ctl.fullWidth && !ctl.rotate) begin
      shOut = {WIDTH{ctl.fill}};
    end else begin
      shOut = stg[STAGES];
    end
  end

  // R1: enabled load captures the input
  a_r1_load: assert property (@(posedge clk) disable iff (rst)
    loadEn |=> (holdReg == $past(dataIn)));

  // R2: without enable the register keeps its value
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !loadEn |=> $stable(holdReg));

  // R6: with no stage and no full-width path the value passes through
  a_r6_passthru: assert property (@(posedge clk) disable iff (rst)
    ((stageEn == '0) && !ctl.fullWidth) |-> (shOut == holdReg));

  // R7: full-width shift leaves only fill bits
  a_r7_full_fill: assert property (@(posedge clk) disable iff (rst)
    (ctl.fullWidth && !ctl.rotate) |-> (shOut == {WIDTH{ctl.fill}}));

  // R4: rotation preserves the number of ones
  a_r4_rot_ones: assert property (@(posedge clk) disable iff (rst)
    ctl.rotate |-> ($countones(shOut) == $countones(holdReg)));

endmodule

// File: rtl/bshift_top.sv
module bshift_top
  import bshift_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int AMT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] dataIn,
  input  logic             loadEn,
  input  logic             dirLeft,
  input  logic             rotEn,
  input  logic             fillBit,
  input  logic [AMT_W-1:0] shiftAmt,
  output logic [WIDTH-1:0] dataOut
);

  localparam int STAGES = $clog2(WIDTH);

  shiftCtl_t         ctlBus;
  logic [STAGES-1:0] stageEn;

  bshift_ctrl #(.WIDTH(WIDTH), .AMT_W(AMT_W)) ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .dirLeft  (dirLeft),
    .rotEn    (rotEn),
    .fillBit  (fillBit),
    .shiftAmt (shiftAmt),
    .ctl      (ctlBus),
    .stageEn  (stageEn)
  );

  bshift_datapath #(.WIDTH(WIDTH)) dp_i (
    .clk     (clk),
    .rst     (rst),
    .dataIn  (dataIn),
    .loadEn  (loadEn),
    .ctl     (ctlBus),
    .stageEn (stageEn),
    .shOut   (dataOut)
  );

endmodule

// File: tb/bshift_top_tb_top.sv
module bshift_top_tb_top;

  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] dataIn;
  logic       loadEn;
  logic       dirLeft;
  logic       rotEn;
  logic       fillBit;
  logic [3:0] shiftAmt;
  logic [7:0] dataOut;

  int   total = 0;
  int   bad   = 0;
  logic [7:0] expReg;
  bit   done = 0;

  always #10 clk = ~clk;

  bshift_top dut_i (
    .clk(clk), .rst(rst), .dataIn(dataIn), .loadEn(loadEn),
    .dirLeft(dirLeft), .rotEn(rotEn), .fillBit(fillBit),
    .shiftAmt(shiftAmt), .dataOut(dataOut)
  );

  function automatic logic [7:0] refModel(logic [7:0] v, logic left, logic rot,
                                          logic fill, logic [3:0] amt);
    int n;
    logic [7:0] r;
    n = (amt > 4'd8) ? 8 : int'(amt);
    r = v;
    for (int s = 0; s < n; s++) begin
      if (left) r = {r[6:0], rot ? r[7] : fill};
      else      r = {rot ? r[0] : fill, r[7:1]};
    end
    return r;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic loadByte(logic [7:0] b);
    @(negedge clk);
    dataIn = b;
    loadEn = 1'b1;
    @(negedge clk);
    loadEn = 1'b0;
    expReg = b;
  endtask

  task automatic setCtl(logic left, logic rot, logic fill, logic [3:0] amt);
    dirLeft = left; rotEn = rot; fillBit = fill; shiftAmt = amt;
    #1;
  endtask

  task automatic tryCtl(string req, logic left, logic rot, logic fill, logic [3:0] amt);
    setCtl(left, rot, fill, amt);
    check(req, dataOut, refModel(expReg, left, rot, fill, amt));
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; loadEn = 1'b0; dataIn = 8'h00;
    dirLeft = 1'b0; rotEn = 1'b0; fillBit = 1'b0; shiftAmt = 4'd0;
    expReg = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check("R3 reset state", dataOut, 8'h00);

    // R1 load, R6 pass-through in every mode
    loadByte(8'hA5);
    for (int m = 0; m < 8; m++)
      tryCtl("R6 amount zero", m[0], m[1], m[2], 4'd0);

    // R2 hold: dataIn toggles with loadEn low across edges
    @(negedge clk); dataIn = 8'h3C;
    @(negedge clk); dataIn = 8'hFF;
    @(negedge clk);
    setCtl(1'b0, 1'b0, 1'b0, 4'd0);
    check("R2 hold without load", dataOut, 8'hA5);

    // R5 directed shifts with fill
    loadByte(8'b1001_0110);
    tryCtl("R5 shift left fill0", 1'b1, 1'b0, 1'b0, 4'd3);
    check("R5 shift left fill0 exact", dataOut, 8'b1011_0000);
    tryCtl("R5 shift right fill1", 1'b0, 1'b0, 1'b1, 4'd3);
    check("R5 shift right fill1 exact", dataOut, 8'b1111_0010);
    // R4 directed rotates
    tryCtl("R4 rotate left", 1'b1, 1'b1, 1'b0, 4'd1);
    check("R4 rotate left exact", dataOut, 8'b0010_1101);
    tryCtl("R4 rotate right", 1'b0, 1'b1, 1'b1, 4'd2);
    check("R4 rotate right exact", dataOut, 8'b1010_0101);

    // R7 full width
    setCtl(1'b1, 1'b0, 1'b1, 4'd8);
    check("R7 shift by 8 fill1", dataOut, 8'hFF);
    setCtl(1'b0, 1'b0, 1'b0, 4'd8);
    check("R7 shift by 8 fill0", dataOut, 8'h00);
    setCtl(1'b1, 1'b1, 1'b0, 4'd8);
    check("R7 rotate by 8", dataOut, 8'b1001_0110);

    // R8 clamp above 8
    for (int a = 9; a < 16; a++) begin
      tryCtl("R8 clamp shift", a[0], 1'b0, a[1], 4'(a));
      tryCtl("R8 clamp rotate", a[0], 1'b1, a[1], 4'(a));
    end

    // R9 combinational response to controls within one low phase
    @(negedge clk);
    tryCtl("R9 same cycle a", 1'b1, 1'b0, 1'b0, 4'd1);
    tryCtl("R9 same cycle b", 1'b0, 1'b1, 1'b0, 4'd5);
    tryCtl("R9 same cycle c", 1'b1, 1'b0, 1'b1, 4'd7);

    // R3 reset wins over a simultaneous load
    @(negedge clk);
    rst = 1'b1; loadEn = 1'b1; dataIn = 8'h77;
    @(negedge clk);
    rst = 1'b0; loadEn = 1'b0;
    expReg = 8'h00;
    setCtl(1'b0, 1'b1, 1'b0, 4'd0);
    check("R3 reset over load", dataOut, 8'h00);

    // Random mix
    for (int it = 0; it < 400; it++) begin
      logic [7:0] b;
      logic [3:0] amt;
      logic l, r, f;
      b = 8'($urandom); amt = 4'($urandom);
      l = 1'($urandom); r = 1'($urandom); f = 1'($urandom);
      if ($urandom % 4 != 0) loadByte(b);
      else begin
        @(negedge clk); dataIn = b;        // R2: not loaded
      end
      if (r) tryCtl("R4 random rotate", l, r, f, amt);
      else   tryCtl("R5 random shift", l, r, f, amt);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule